// File: doc/BRIEF.md
# Shared-Operand Broadcast Fetch Unit

This block drives a group of identical worker lanes that all walk the same constant array. Rather than have every lane fetch the array on its own, a single sequencer reads each array word from memory once and presents it to all lanes in the same cycle. Each lane multiplies the word by its own private scalar and adds the product to a running sum. Once every element has been consumed, the group reports its per-lane sums together with a done flag.

The block stays idle until the enable input rises. On that rising edge it clears all lane sums, captures each lane's scalar and latches the array base address. It then issues reads on a valid/ready request channel. Back-pressure on that channel works as follows. A request stays valid with a stable address until the memory accepts it. The address advances only on an accepted handshake. The response channel has no back-pressure: the block takes every response word that arrives while a run is active, in request order. With G lanes and an array of L words, a run makes L memory reads instead of G×L.

Top module: `sobf_top`

## Requirements
- R1: A rising edge of `enable` (high now, low in the previous cycle) starts a run. All `lane_result` fields read zero in the cycle after that edge.
- R2: A run issues exactly ARR_LEN accepted read requests. Their addresses are `base_addr`+0, +1, … +ARR_LEN-1, in increasing order, where `base_addr` is the value sampled at the start edge.
- R3: While `rd_req_valid` is high and `rd_req_ready` is low, with `enable` high, the next cycle keeps `rd_req_valid` high and `rd_req_addr` unchanged.
- R4: Every response word accepted during a run is added to all lanes in the same cycle. Lane k gains data×scalar_k. The final field k equals the unsigned dot product of the array with scalar_k.
- R5: A response that arrives while no run is active changes no lane result.
- R6: `done` goes high in the cycle after the final (ARR_LEN-th) response is presented and stays high while `enable` is high. The results stay unchanged while `done` is high.
- R7: With `enable` low, `done` is low from the next cycle on and no request is issued. The lane results keep their last values.
- R8: Each lane's scalar is captured at the start edge. Changes on `lane_scalar` during a run do not affect the sums.
- R9: Each result field is ACC_W = DATA_W+SCALAR_W+clog2(ARR_LEN+1) bits wide. An all-ones array times all-ones scalars gives the exact sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Rising edge starts a run; low returns to idle |
| base_addr | input | ADDR_W | First array address, sampled at start |
| lane_scalar | input | LANES*SCALAR_W | Per-lane scalar, lane k in bits [k*SCALAR_W +: SCALAR_W] |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Response word valid (always accepted) |
| rd_rsp_data | input | DATA_W | Response word |
| lane_result | output | LANES*ACC_W | Per-lane sums, lane k in bits [k*ACC_W +: ACC_W] |
| done | output | 1 | All array words accumulated |

## Verification
The start edge clears the sums, so they read zero at the next falling edge, one cycle later. The first request is valid in that same cycle. The test memory returns the word one cycle after each accepted request. A lane sum moves at the rising edge that follows a presented response. `done` rises at the same edge as the final sum, so the bench expects it at the falling edge after the one where it saw the last response valid, and checks it low before then. Dropping `enable` clears `done` at the next edge. All samples are taken at falling edges, where each of these effects is fully settled.

// File: rtl/sobf_pkg.sv
package sobf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FULL = 2'd2
  } run_state_e;

  // counter width able to hold 0..n
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // accumulator width that cannot overflow for n products
  function automatic int sum_bits(input int dw, input int sw, input int n);
    return dw + sw + cnt_bits(n);
  endfunction

endpackage

// File: rtl/sobf_fetch_seq.sv
module sobf_fetch_seq
  import sobf_pkg::*;
#(
  parameter int ARR_LEN = 10,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = cnt_bits(ARR_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_ready,
  input  logic              rsp_valid,
  output logic              start_pulse,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              take,
  output logic              done
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ARR_LEN - 1);
  localparam logic [CNT_W-1:0] LEN_CNT  = CNT_W'(ARR_LEN);

  run_state_e        state;
  logic              enable_q;
  logic [CNT_W-1:0]  issued;
  logic [CNT_W-1:0]  received;
  logic [ADDR_W-1:0] base_q;

  assign start_pulse = enable & ~enable_q;
  assign req_valid   = (state == ST_RUN) && (issued < LEN_CNT);
  assign req_addr    = base_q + ADDR_W'(issued);
  assign take        = (state == ST_RUN) && rsp_valid;
  assign done        = (state == ST_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      enable_q <= 1'b0;
      issued   <= '0;
      received <= '0;
      base_q   <= '0;
    end else begin
      enable_q <= enable;
      if (!enable) begin
        state <= ST_IDLE;
      end else if (start_pulse) begin
        state    <= ST_RUN;
        issued   <= '0;
        received <= '0;
        base_q   <= base_addr;
      end else if (state == ST_RUN) begin
        if (req_valid && req_ready) begin
          issued <= issued + 1'b1;
        end
        if (take) begin
          received <= received + 1'b1;
          if (received == LAST_IDX) begin
            state <= ST_FULL;
          end
        end
      end
    end
  end

endmodule

// File: rtl/sobf_lane.sv
module sobf_lane #(
  parameter int DATA_W   = 16,
  parameter int SCALAR_W = 16,
  parameter int ACC_W    = 36
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic [SCALAR_W-1:0] scalar_in,
  input  logic                take,
  input  logic [DATA_W-1:0]   data_in,
  output logic [ACC_W-1:0]    acc_out
);

  localparam int PROD_W = DATA_W + SCALAR_W;

  logic [SCALAR_W-1:0] scalar_q;
  logic [PROD_W-1:0]   prod;
  logic [ACC_W-1:0]    acc;

  assign prod    = PROD_W'(data_in) * PROD_W'(scalar_q);
  assign acc_out = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scalar_q <= '0;
      acc      <= '0;
    end else if (clear) begin
      scalar_q <= scalar_in;
      acc      <= '0;
    end else if (take) begin
      acc <= acc + ACC_W'(prod);
    end
  end

endmodule

// File: rtl/sobf_lane_array.sv
module sobf_lane_array #(
  parameter int LANES    = 8,
  parameter int DATA_W   = 16,
  parameter int SCALAR_W = 16,
  parameter int ACC_W    = 36
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clear,
  input  logic [LANES*SCALAR_W-1:0] scalars,
  input  logic                      take,
  input  logic [DATA_W-1:0]         bcast_data,
  output logic [LANES*ACC_W-1:0]    sums
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sobf_lane #(
      .DATA_W  (DATA_W),
      .SCALAR_W(SCALAR_W),
      .ACC_W   (ACC_W)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clear),
      .scalar_in(scalars[k*SCALAR_W +: SCALAR_W]),
      .take     (take),
      .data_in  (bcast_data),
      .acc_out  (sums[k*ACC_W +: ACC_W])
    );
  end

endmodule

// File: rtl/sobf_top.sv
module sobf_top
  import sobf_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int ARR_LEN  = 10,
  parameter int DATA_W   = 16,
  parameter int SCALAR_W = 16,
  parameter int ADDR_W   = 8,
  parameter int ACC_W    = sum_bits(DATA_W, SCALAR_W, ARR_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enable,
  input  logic [ADDR_W-1:0]         base_addr,
  input  logic [LANES*SCALAR_W-1:0] lane_scalar,
  output logic                      rd_req_valid,
  input  logic                      rd_req_ready,
  output logic [ADDR_W-1:0]         rd_req_addr,
  input  logic                      rd_rsp_valid,
  input  logic [DATA_W-1:0]         rd_rsp_data,
  output logic [LANES*ACC_W-1:0]    lane_result,
  output logic                      done
);

  localparam int CNT_W = cnt_bits(ARR_LEN);

  logic start_pulse;
  logic take;

  sobf_fetch_seq #(
    .ARR_LEN(ARR_LEN),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .base_addr  (base_addr),
    .req_ready  (rd_req_ready),
    .rsp_valid  (rd_rsp_valid),
    .start_pulse(start_pulse),
    .req_valid  (rd_req_valid),
    .req_addr   (rd_req_addr),
    .take       (take),
    .done       (done)
  );

  sobf_lane_array #(
    .LANES   (LANES),
    .DATA_W  (DATA_W),
    .SCALAR_W(SCALAR_W),
    .ACC_W   (ACC_W)
  ) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_pulse),
    .scalars   (lane_scalar),
    .take      (take),
    .bcast_data(rd_rsp_data),
    .sums      (lane_result)
  );

endmodule

// File: rtl/sobf_checker.sv
module sobf_checker #(
  parameter int LANES   = 8,
  parameter int ARR_LEN = 10,
  parameter int ADDR_W  = 8,
  parameter int ACC_W   = 36
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   enable,
  input logic                   rd_req_valid,
  input logic                   rd_req_ready,
  input logic [ADDR_W-1:0]      rd_req_addr,
  input logic [LANES*ACC_W-1:0] lane_result,
  input logic                   done
);

  logic en_q;
  int   req_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      req_cnt <= 0;
    end else begin
      en_q <= enable;
      if (enable && !en_q) begin
        req_cnt <= 0;
      end else if (rd_req_valid && rd_req_ready && req_cnt < ARR_LEN) begin
        req_cnt <= req_cnt + 1;
      end
    end
  end

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |=> (lane_result == '0));

  p_req_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && req_cnt == ARR_LEN) |-> !rd_req_valid);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready && enable) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && enable) |=> $stable(lane_result));

  p_done_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> en_q);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!done && !rd_req_valid));

endmodule

bind sobf_top sobf_checker #(
  .LANES  (LANES),
  .ARR_LEN(ARR_LEN),
  .ADDR_W (ADDR_W),
  .ACC_W  (ACC_W)
) u_sobf_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .lane_result (lane_result),
  .done        (done)
);

// File: tb/sobf_top_bench.sv
module sobf_top_bench;

  localparam int LANES  = 8;
  localparam int LEN    = 10;
  localparam int DW     = 16;
  localparam int SW     = 16;
  localparam int AW     = 8;
  localparam int ACCW   = DW + SW + $clog2(LEN + 1);
  localparam int HALF_T = 2500; // time unit 1 ps: 5 ns period

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 enable = 1'b0;
  logic [AW-1:0]        base_addr = '0;
  logic [LANES*SW-1:0]  lane_scalar = '0;
  logic                 rd_req_valid;
  logic                 rd_req_ready;
  logic [AW-1:0]        rd_req_addr;
  logic                 rd_rsp_valid;
  logic [DW-1:0]        rd_rsp_data;
  logic [LANES*ACCW-1:0] lane_result;
  logic                 done;

  sobf_top u_sobf_top (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_addr(base_addr),
    .lane_scalar(lane_scalar), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .lane_result(lane_result), .done(done)
  );

  always #HALF_T clk = ~clk;

  // memory model and bookkeeping
  logic [DW-1:0] mem [256];
  int  rmode = 0;      // 0: ready 3/4, 1: always, 2: ready 1/4
  bit  inject = 1'b0;
  int  reads = 0;
  int  addr_err = 0;
  int  hold_err = 0;
  int  base_cur = 0;
  bit  prev_wait = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  int  n_chk = 0;
  int  n_fail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
      prev_wait    <= 1'b0;
    end else begin
      if (prev_wait && (!rd_req_valid || rd_req_addr != prev_addr)) hold_err++;
      prev_wait <= rd_req_valid && !rd_req_ready && enable;
      prev_addr <= rd_req_addr;
      if (rd_req_valid && rd_req_ready) begin
        if (int'(rd_req_addr) != base_cur + reads) addr_err++;
        reads++;
      end
      case (rmode)
        1:       rd_req_ready <= 1'b1;
        2:       rd_req_ready <= ($urandom % 4) == 0;
        default: rd_req_ready <= ($urandom % 4) != 0;
      endcase
      rd_rsp_valid <= (rd_req_valid && rd_req_ready) || inject;
      rd_rsp_data  <= inject ? {DW{1'b1}} : mem[rd_req_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] dot(input int base, input logic [SW-1:0] s);
    logic [63:0] acc = 0;
    for (int i = 0; i < LEN; i++) acc += 64'(mem[base + i]) * 64'(s);
    return acc;
  endfunction

  function automatic logic [63:0] res(input int k);
    return 64'(lane_result[k*ACCW +: ACCW]);
  endfunction

  logic [63:0] expv [LANES];

  task automatic run_group(input int base, input bit change_mid);
    logic [SW-1:0] sc [LANES];
    int seen = 0;
    bit fin = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      sc[k] = lane_scalar[k*SW +: SW];
      expv[k] = dot(base, sc[k]);
    end
    base_addr = AW'(base);
    base_cur = base;
    reads = 0;
    enable = 1'b1;
    @(negedge clk);
    // R1: start edge has cleared the sums
    for (int k = 0; k < LANES; k++) chk(res(k) == 0, "R1", res(k), 0);
    for (int c = 0; c < 3000 && !fin; c++) begin
      if (seen == LEN) begin
        chk(done == 1'b1, "R6", 64'(done), 1); // due one cycle after last response
        fin = 1'b1;
      end else begin
        if (done) chk(1'b0, "R6", 64'(done), 0);
        if (rd_rsp_valid) seen++;
        if (change_mid && c == 3) lane_scalar = {LANES{16'h5A5A}}; // R8
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, "R6 watchdog", 64'(seen), 64'(LEN));
    for (int k = 0; k < LANES; k++) chk(res(k) == expv[k], "R4/R8/R9", res(k), expv[k]);
    chk(reads == LEN, "R2 read count", 64'(reads), 64'(LEN));
    chk(addr_err == 0, "R2 address order", 64'(addr_err), 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R6 held", 64'(done), 1);
    chk(res(0) == expv[0] && res(LANES-1) == expv[LANES-1], "R6 stable", res(0), expv[0]);
    enable = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R7 done drop", 64'(done), 0);
    chk(rd_req_valid == 1'b0, "R7 no request", 64'(rd_req_valid), 0);
    chk(res(1) == expv[1], "R7 retain", res(1), expv[1]);
    @(negedge clk);
  endtask

  task automatic set_scalars_random();
    for (int k = 0; k < LANES; k++) lane_scalar[k*SW +: SW] = SW'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < 256; a++) mem[a] = DW'($urandom);
    for (int a = 200; a < 210; a++) mem[a] = {DW{1'b1}};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "reset done", 64'(done), 0);
    chk(rd_req_valid == 1'b0, "reset req", 64'(rd_req_valid), 0);
    chk(lane_result == '0, "reset result", res(0), 0);

    // R9: all-ones data and scalars, full-rate memory
    rmode = 1;
    lane_scalar = {LANES{16'hFFFF}};
    run_group(200, 1'b0);

    // zero and one scalars, slow memory
    rmode = 2;
    for (int k = 0; k < LANES; k++) lane_scalar[k*SW +: SW] = SW'(k % 2);
    run_group(0, 1'b0);

    // R5: stray response while idle leaves results alone
    inject = 1'b1;
    @(negedge clk);
    inject = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < LANES; k++) chk(res(k) == expv[k], "R5", res(k), expv[k]);

    // R8: scalars change during the run
    rmode = 0;
    set_scalars_random();
    run_group(37, 1'b1);

    // random runs
    for (int r = 0; r < 6; r++) begin
      rmode = int'($urandom % 3);
      set_scalars_random();
      run_group(int'($urandom % (256 - LEN)), 1'b0);
    end

    // top of address space
    rmode = 0;
    set_scalars_random();
    run_group(256 - LEN, 1'b0);

    chk(hold_err == 0, "R3 request hold", 64'(hold_err), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule